// File: doc/BRIEF.md
# I2C Master Bus-Condition Sequencer

This block is the part of an I2C master that ends a transfer. Software writes four control bits in one command: master, transmit, busy and pending. From that command the block drives the open-drain enables for SDA and SCL. One encoding makes it produce a stop condition. A second encoding releases both lines so that a repeated start can follow. Every other encoding leaves the lines alone.

Before SDA is allowed to rise, the stop sequence waits for SCL to read high. A slave that stretches the clock therefore delays completion of the stop. A bus monitor watches the synchronised lines, sets a busy flag on a start pattern and clears it only on a stop pattern. A status bit mirrors the synchronised SCL level, so software can tell whether anything still holds the clock low.

Start generation itself sits elsewhere. A start request is queued here and passed on as a one-cycle pulse. The pulse is issued only once the bus is idle and the minimum setup interval after a restart release has run out.

Top module: `i2c_cond_seq`

## Requirements
- R1: After synchronous reset, sda_oe=0, scl_oe=0, stat_busy=0, stat_pend=1, stat_lastbit=1 (lines idle high) and start_go=0.
- R2: A write with cmd_master=1, cmd_xmit=1, cmd_busy=0, cmd_pend=1, accepted while idle, asserts sda_oe and scl_oe together in the cycle after the write.
- R3: During a stop, once the block has released SCL, sda_oe stays asserted for as long as the synchronised SCL reads low. A clock held low by another device therefore delays the stop indefinitely.
- R4: Once the synchronised SCL reads high, sda_oe is released HOLD_CYC cycles later. Measured from the scl_oe release on an unstretched bus, that is HOLD_CYC+3 cycles. SDA is released only while SCL is seen high, which completes the stop.
- R5: A write with cmd_master=0, cmd_xmit=0, cmd_busy=0, cmd_pend=1 releases both lines and leaves stat_busy unchanged.
- R6: stat_busy goes to 1 when SDA falls while SCL is high. It goes to 0 only when SDA rises while SCL is high.
- R7: stat_lastbit equals the SCL line level seen through the SYNC_STAGES-flop synchroniser: 1 when no device holds SCL low.
- R8: A start_req pulse is held pending. It produces exactly one single-cycle start_go pulse, and only after stat_busy=0 and the setup timer has expired.
- R9: After a restart release, start_go is not issued earlier than SETUP_CYC cycles later.
- R10: Writes with any other bit combination, and any write while a stop is in progress, change neither the line enables nor stat_busy.
- R11: stat_pend takes the cmd_pend value of every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_master | input | 1 | Master bit of the command |
| cmd_xmit | input | 1 | Transmit bit of the command |
| cmd_busy | input | 1 | Busy bit of the command |
| cmd_pend | input | 1 | Pending bit of the command |
| start_req | input | 1 | Request to generate a start (queued) |
| sda_in | input | 1 | Sampled SDA line |
| scl_in | input | 1 | Sampled SCL line |
| sda_oe | output | 1 | SDA pull-low enable (1 drives low) |
| scl_oe | output | 1 | SCL pull-low enable (1 drives low) |
| start_go | output | 1 | One-cycle pulse passing a start request on |
| stat_busy | output | 1 | Bus busy flag |
| stat_lastbit | output | 1 | Synchronised SCL level |
| stat_pend | output | 1 | Last written pending bit |

## Verification
The command decode is exercised by a table of encodings, each applied from one of several prepared bus states: idle, busy after an emulated start, or with SCL held low by another device.

- Stop against restart on a busy bus shows whether busy is cleared only by a real stop.
- Stop with the clock held low separates correct clock-stretch waiting from an early SDA release.
- Encodings that differ by one bit confirm that only the two exact patterns act.

Directed cases then measure the SDA hold delay after SCL rises and the setup delay before start_go. They also check that a queued start is held back while the bus is busy and that writes made mid-stop are ignored.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
    localparam int CNT_W = 16;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_PULL,
        SQ_REL_SCL,
        SQ_HOLD
    } seq_state_e;

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             sda_oe;
        logic             scl_oe;
    } seq_regs_t;

    typedef struct packed {
        logic sda_prev;
        logic scl_prev;
        logic busy;
    } mon_regs_t;

    typedef struct packed {
        logic start_pend;
        logic start_go;
        logic stat_pend;
    } top_regs_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            if (STAGES > 1) chain_d = {chain_q[STAGES-2:0], din[b]};
            else            chain_d = din[b];
        end

        always_ff @(posedge clk) begin
            if (rst) chain_q <= '1;
            else     chain_q <= chain_d;
        end

        assign dout[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
    import i2c_cond_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sda_s,
    input  logic scl_s,
    output logic busy
);
    mon_regs_t r_d, r_q;
    logic start_seen, stop_seen;

    always_comb begin
        r_d          = r_q;
        start_seen   = r_q.sda_prev && !sda_s && scl_s && r_q.scl_prev;
        stop_seen    = !r_q.sda_prev && sda_s && scl_s && r_q.scl_prev;
        r_d.sda_prev = sda_s;
        r_d.scl_prev = scl_s;
        if (start_seen)     r_d.busy = 1'b1;
        else if (stop_seen) r_d.busy = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{sda_prev: 1'b1, scl_prev: 1'b1, busy: 1'b0};
        else     r_q <= r_d;
    end

    assign busy = r_q.busy;

    // R6: busy only clears after SDA was seen high with SCL high
    p_busy_fall_on_stop_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(r_q.busy) |-> ($past(sda_s) && $past(scl_s)));
    // R6: busy only sets after SDA was seen low with SCL high
    p_busy_rise_on_start_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(r_q.busy) |-> (!$past(sda_s) && $past(scl_s)));
endmodule

// File: rtl/i2c_setup_timer.sv
module i2c_setup_timer
    import i2c_cond_pkg::*;
#(
    parameter int SETUP_CYC = 235
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic done
);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETUP_CYC);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)             cnt_d = LOAD_VAL;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    // R9: the counter never exceeds its load value
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LOAD_VAL);
endmodule

// File: rtl/i2c_stop_seq.sv
module i2c_stop_seq
    import i2c_cond_pkg::*;
#(
    parameter int HOLD_CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic do_stop,
    input  logic do_restart,
    input  logic scl_s,
    output logic sda_oe,
    output logic scl_oe,
    output logic idle,
    output logic restart_ld
);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

    seq_regs_t r_d, r_q;

    always_comb begin
        r_d        = r_q;
        restart_ld = 1'b0;
        unique case (r_q.state)
            SQ_IDLE: begin
                if (do_stop) begin
                    r_d.state  = SQ_PULL;
                    r_d.sda_oe = 1'b1;
                    r_d.scl_oe = 1'b1;
                end else if (do_restart) begin
                    r_d.sda_oe = 1'b0;
                    r_d.scl_oe = 1'b0;
                    restart_ld = 1'b1;
                end
            end
            SQ_PULL: begin
                if (!scl_s) begin
                    r_d.state  = SQ_REL_SCL;
                    r_d.scl_oe = 1'b0;
                end
            end
            SQ_REL_SCL: begin
                if (scl_s) begin
                    r_d.state = SQ_HOLD;
                    r_d.cnt   = '0;
                end
            end
            SQ_HOLD: begin
                if (!scl_s) begin
                    r_d.state = SQ_REL_SCL;
                end else if (r_q.cnt == HOLD_LAST) begin
                    r_d.state  = SQ_IDLE;
                    r_d.sda_oe = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{state: SQ_IDLE, cnt: '0, sda_oe: 1'b0, scl_oe: 1'b0};
        else     r_q <= r_d;
    end

    assign sda_oe = r_q.sda_oe;
    assign scl_oe = r_q.scl_oe;
    assign idle   = (r_q.state == SQ_IDLE);

    // R2: SDA and SCL are pulled together when a stop begins
    p_pull_together_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(r_q.sda_oe) |-> $rose(r_q.scl_oe));
    // R3: SDA kept low while the released clock still reads low
    p_sda_kept_r3: assert property (@(posedge clk) disable iff (rst)
        (r_q.sda_oe && !r_q.scl_oe && !scl_s) |=> r_q.sda_oe);
    // R4: SDA only released while SCL was seen high
    p_release_scl_high_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(r_q.sda_oe) |-> $past(scl_s));
endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq
    import i2c_cond_pkg::*;
#(
    parameter int SETUP_CYC   = 235,
    parameter int HOLD_CYC    = 200,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd_wr,
    input  logic cmd_master,
    input  logic cmd_xmit,
    input  logic cmd_busy,
    input  logic cmd_pend,
    input  logic start_req,
    input  logic sda_in,
    input  logic scl_in,
    output logic sda_oe,
    output logic scl_oe,
    output logic start_go,
    output logic stat_busy,
    output logic stat_lastbit,
    output logic stat_pend
);
    logic [1:0] line_s;
    logic       sda_s, scl_s;
    logic       busy, seq_idle, restart_ld, timer_done;
    logic       wr_stop, wr_restart;
    top_regs_t  r_d, r_q;

    i2c_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({sda_in, scl_in}),
        .dout (line_s)
    );
    assign sda_s = line_s[1];
    assign scl_s = line_s[0];

    i2c_bus_monitor u_mon (
        .clk   (clk),
        .rst   (rst),
        .sda_s (sda_s),
        .scl_s (scl_s),
        .busy  (busy)
    );

    assign wr_stop    = cmd_wr &&  cmd_master &&  cmd_xmit && !cmd_busy && cmd_pend;
    assign wr_restart = cmd_wr && !cmd_master && !cmd_xmit && !cmd_busy && cmd_pend;

    i2c_stop_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .do_stop    (wr_stop),
        .do_restart (wr_restart),
        .scl_s      (scl_s),
        .sda_oe     (sda_oe),
        .scl_oe     (scl_oe),
        .idle       (seq_idle),
        .restart_ld (restart_ld)
    );

    i2c_setup_timer #(.SETUP_CYC(SETUP_CYC)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (restart_ld),
        .done (timer_done)
    );

    always_comb begin
        r_d          = r_q;
        r_d.start_go = 1'b0;
        if (cmd_wr) r_d.stat_pend = cmd_pend;
        if (start_req) r_d.start_pend = 1'b1;
        if (r_q.start_pend && !busy && timer_done && seq_idle && !restart_ld) begin
            r_d.start_go   = 1'b1;
            r_d.start_pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{start_pend: 1'b0, start_go: 1'b0, stat_pend: 1'b1};
        else     r_q <= r_d;
    end

    assign start_go     = r_q.start_go;
    assign stat_busy    = busy;
    assign stat_lastbit = scl_s;
    assign stat_pend    = r_q.stat_pend;

    // R8: start_go is a single-cycle pulse
    p_go_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        start_go |=> !start_go);
    // R8: start_go only follows a free bus and an expired timer
    p_go_free_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(start_go) |-> ($past(!busy) && $past(timer_done)));
endmodule

// File: tb/i2c_cond_seq_tb.sv
module i2c_cond_seq_tb;
    localparam int SETUP = 235;
    localparam int HOLD  = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_wr = 0, cmd_master = 0, cmd_xmit = 0, cmd_busy = 0, cmd_pend = 0;
    logic start_req = 0;
    logic ext_sda_low = 0, ext_scl_low = 0;
    logic sda_oe, scl_oe, start_go, stat_busy, stat_lastbit, stat_pend;
    logic sda_line, scl_line;
    int   n_run = 0, n_fail = 0;
    bit   finished = 0;

    always #10 clk = ~clk;

    assign sda_line = ~(sda_oe | ext_sda_low);
    assign scl_line = ~(scl_oe | ext_scl_low);

    i2c_cond_seq #(.SETUP_CYC(SETUP), .HOLD_CYC(HOLD), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_master(cmd_master),
        .cmd_xmit(cmd_xmit), .cmd_busy(cmd_busy), .cmd_pend(cmd_pend),
        .start_req(start_req), .sda_in(sda_line), .scl_in(scl_line),
        .sda_oe(sda_oe), .scl_oe(scl_oe), .start_go(start_go),
        .stat_busy(stat_busy), .stat_lastbit(stat_lastbit), .stat_pend(stat_pend)
    );

    // {pre_busy, hold_scl, m, x, b, p, exp_sda_oe, exp_scl_oe, exp_busy, exp_last, exp_pend}
    localparam logic [10:0] VEC [0:8] = '{
        11'b00_1101_00011,   // R2 R4 stop from idle
        11'b10_1101_00011,   // R6 stop clears busy
        11'b11_1101_10101,   // R3 stop waits on held clock
        11'b00_0001_00011,   // R5 restart from idle
        11'b10_0001_00111,   // R5 restart keeps busy
        11'b10_1111_00111,   // R10 busy bit set: ignored
        11'b10_1100_00110,   // R10 R11 pending bit clear: ignored
        11'b01_0101_00001,   // R10 R7 held clock, other encoding
        11'b11_0001_00101    // R5 R7 restart with held clock
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ext_sda_low = 0; ext_scl_low = 0; start_req = 0; cmd_wr = 0;
        cycles(3);
        rst = 1'b0;
        cycles(4);
    endtask

    task automatic write_cmd(input logic [3:0] c);
        {cmd_master, cmd_xmit, cmd_busy, cmd_pend} = c;
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic emulate_start();
        ext_sda_low = 1; cycles(6);
        ext_scl_low = 1; cycles(6);
        ext_sda_low = 0; cycles(6);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt;
        int pulses;
        do_reset();
        // R1 reset state
        chk(!sda_oe && !scl_oe, "R1 lines", {sda_oe, scl_oe}, 0);
        chk(!stat_busy, "R1 busy", stat_busy, 0);
        chk(stat_pend, "R1 pend", stat_pend, 1);
        chk(stat_lastbit, "R1 lastbit", stat_lastbit, 1);
        chk(!start_go, "R1 start_go", start_go, 0);

        // vector table
        for (int i = 0; i < 9; i++) begin
            logic [10:0] v;
            v = VEC[i];
            do_reset();
            if (v[10]) begin
                emulate_start();
                chk(stat_busy, "R6 busy after start", stat_busy, 1);
                if (!v[9]) begin ext_scl_low = 0; cycles(6); end
            end else if (v[9]) begin
                ext_scl_low = 1; cycles(6);
            end
            write_cmd(v[8:5]);
            if (v[8:5] == 4'b1101) begin
                chk(sda_oe && scl_oe, "R2 both pulled", {sda_oe, scl_oe}, 3);
            end
            cycles(600);
            chk(sda_oe == v[4], $sformatf("R3 R4 R5 R10 vec%0d sda_oe", i), sda_oe, v[4]);
            chk(scl_oe == v[3], $sformatf("R3 R5 R10 vec%0d scl_oe", i), scl_oe, v[3]);
            chk(stat_busy == v[2], $sformatf("R5 R6 R10 vec%0d busy", i), stat_busy, v[2]);
            chk(stat_lastbit == v[1], $sformatf("R7 vec%0d lastbit", i), stat_lastbit, v[1]);
            chk(stat_pend == v[0], $sformatf("R11 vec%0d pend", i), stat_pend, v[0]);
        end

        // R4 hold delay from scl release to sda release
        do_reset();
        write_cmd(4'b1101);
        cnt = 0;
        while (scl_oe && cnt < 50) begin @(negedge clk); cnt++; end
        cnt = 0;
        while (sda_oe && cnt < HOLD + 50) begin @(negedge clk); cnt++; end
        chk(cnt >= HOLD + 2 && cnt <= HOLD + 4, "R4 hold cycles", cnt, HOLD + 3);

        // R3 R10 stretch, mid-sequence write ignored, then completion
        do_reset();
        emulate_start();
        write_cmd(4'b1101);
        cycles(60);
        write_cmd(4'b0001);
        cycles(60);
        chk(sda_oe && !scl_oe, "R3 R10 sda held during stretch", {sda_oe, scl_oe}, 2);
        chk(stat_busy, "R3 busy during stretch", stat_busy, 1);
        ext_scl_low = 0;
        cycles(HOLD + 20);
        chk(!sda_oe, "R3 released after clock freed", sda_oe, 0);
        chk(!stat_busy, "R6 busy cleared by stop", stat_busy, 0);

        // R9 setup delay after restart release
        do_reset();
        start_req = 1;
        write_cmd(4'b0001);
        start_req = 0;
        cnt = 1;
        while (!start_go && cnt < SETUP + 50) begin @(negedge clk); cnt++; end
        chk(cnt >= SETUP && cnt <= SETUP + 2, "R9 setup delay", cnt, SETUP + 1);

        // R8 queued start held while busy, released after bus stop
        do_reset();
        emulate_start();
        ext_scl_low = 0; cycles(6);
        start_req = 1; @(negedge clk); start_req = 0;
        pulses = 0;
        for (int k = 0; k < 400; k++) begin @(negedge clk); if (start_go) pulses++; end
        chk(pulses == 0, "R8 held while busy", pulses, 0);
        ext_sda_low = 1; cycles(6);
        ext_sda_low = 0;
        pulses = 0;
        for (int k = 0; k < 30; k++) begin @(negedge clk); if (start_go) pulses++; end
        chk(!stat_busy, "R6 busy cleared by bus stop", stat_busy, 0);
        chk(pulses == 1, "R8 single start_go", pulses, 1);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule